// File: doc/BRIEF.md
# Instruction Fetch Stage with Register-Target Jump Redirect

This block is the front end of a three-stage 32-bit pipeline (fetch, execute, writeback). It keeps the program counter, the instruction now being handed to execute and the one handed over a step earlier. It also drives the address port of a program memory whose read data comes back one clock after the address is presented. Each architectural step either moves to the next word, four bytes on, or follows a taken jump to a target address. That target is the value that execute reads out of the register file for the jump's C field.

A jump is an instruction whose opcode byte is 0x0B. Execute evaluates the condition and raises a taken flag while the jump sits in the current instruction register. The program memory answers only one clock after it sees an address, so the target word cannot be in hand in the cycle the jump is reported taken. The fetch stage therefore spends one extra cycle on a redirect. In the reporting cycle it presents the target address and freezes its state. In the following fill cycle it completes the architectural step: the program counter becomes the target, the current instruction register receives the word at the target, and the jump moves into the previous instruction register. A step strobe marks every cycle whose closing edge performs one architectural step, so that a reference model can be advanced in lockstep.

The memory port has a fixed one-cycle latency and no back-pressure. The address output is valid in every cycle, and the read data is consumed exactly one clock later. The stage never waits for the memory, and the memory cannot stall the stage. Back-pressure from later stages is not part of this block.

Top module: `ifetch_stage`

## Requirements
- R1: While reset is held, the PC is RESET_PC (0 by default), and the current and previous instruction registers are all-zero (a NOP, opcode 0). In the first cycle after reset is released, step is low, the memory address equals the PC, and no register changes.
- R2: On a step that is not a taken jump and not a fill, the PC advances by PC_STEP (4). The current instruction register receives the word read at the old PC.
- R3: On every step, the previous instruction register receives the old current instruction. In a cycle with step low, the PC and both instruction registers keep their values.
- R4: The taken flag is honoured only when bits 31:24 of the current instruction equal 0x0B. With any other opcode, a raised taken flag is ignored and fetch steps sequentially. A jump that is reported not taken also steps sequentially.
- R5: In a cycle where a jump is reported taken, step is low, the memory address equals the jump target input, and no register changes. The next cycle is a fill cycle, with step high. At its end the PC holds that target, the current instruction is the word at the target, and the previous instruction is the jump. During the fill cycle the taken flag and the target input are ignored.
- R6: In a sequential step the memory address equals the PC plus PC_STEP. During a fill cycle the memory address is the captured target. Read data is used exactly one clock after its address.
- R7: The step output is high exactly in the cycles whose closing edge performs one architectural step.
- R8: A jump landed on by a redirect can itself be taken in the cycle right after the fill.
- R9: The first step after a fill reads the target word again. The PC then moves to target plus PC_STEP, and both instruction registers hold the target word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| jmp_taken_i | input | 1 | Execute reports that the jump in the current instruction register is taken |
| jmp_target_i | input | XLEN | Register value named by field C of the current jump |
| imem_rdata_i | input | XLEN | Program memory read data, one clock after its address |
| imem_addr_o | output | XLEN | Program memory read address |
| pc_o | output | XLEN | Program counter |
| cur_instr_o | output | XLEN | Current instruction register |
| prev_instr_o | output | XLEN | Previous instruction register |
| step_o | output | 1 | High when this cycle's edge performs one architectural step |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit opcode field at the top of the word, a step of 4, jump opcode 0x0B and a reset PC of 0. With these values the program counter runs past the 8-bit address boundary at 0x100. The same values let one run cover three cases: a taken jump whose target holds another jump, a jump reported not taken, and a taken flag raised beside an ordinary instruction. The bench then asserts reset between two steps and checks the priming cycle that follows.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  // Sequencing states of the fetch stage
  typedef enum logic [1:0] {
    FS_PRIME = 2'd0,  // first cycle after reset: present PC, hold state
    FS_RUN   = 2'd1,  // normal stepping, jump may be reported taken
    FS_FILL  = 2'd2   // target word arriving, complete the jump step
  } fstate_e;

endpackage

// File: rtl/ifetch_jdec.sv
module ifetch_jdec #(
  parameter int unsigned OP_W   = 8,
  parameter logic [OP_W-1:0] JMP_OP = 8'h0B
) (
  input  logic [OP_W-1:0] opcode_i,
  output logic            is_jmp_o
);

  assign is_jmp_o = (opcode_i == JMP_OP);

endmodule

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    is_jmp_i,
  input  logic    taken_i,
  output fstate_e state_o,
  output logic    take_o,
  output logic    step_o
);

  fstate_e state_q, state_d;

  // A taken report only counts in a running cycle holding a jump
  assign take_o = (state_q == FS_RUN) && is_jmp_i && taken_i;

  always_comb begin
    state_d = state_q;
    step_o  = 1'b0;
    case (state_q)
      FS_PRIME: state_d = FS_RUN;
      FS_RUN: begin
        if (take_o) begin
          state_d = FS_FILL;
        end else begin
          step_o = 1'b1;
        end
      end
      FS_FILL: begin
        step_o  = 1'b1;
        state_d = FS_RUN;
      end
      default: state_d = FS_PRIME;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_PRIME;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/ifetch_addr.sv
module ifetch_addr
  import ifetch_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fstate_e         state_i,
  input  logic            take_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] next_pc_o
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(PC_STEP);

  logic [XLEN-1:0] tgt_q;
  logic [XLEN-1:0] seq_pc;

  assign seq_pc = pc_i + STEP_V;

  // Target is captured in the reporting cycle, used in the fill cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
    end else if (take_i) begin
      tgt_q <= target_i;
    end
  end

  always_comb begin
    addr_o    = pc_i;
    next_pc_o = pc_i;
    case (state_i)
      FS_PRIME: begin
        addr_o    = pc_i;
        next_pc_o = pc_i;
      end
      FS_RUN: begin
        if (take_i) begin
          addr_o    = target_i;
          next_pc_o = pc_i;
        end else begin
          addr_o    = seq_pc;
          next_pc_o = seq_pc;
        end
      end
      FS_FILL: begin
        addr_o    = tgt_q;
        next_pc_o = tgt_q;
      end
      default: begin
        addr_o    = pc_i;
        next_pc_o = pc_i;
      end
    endcase
  end

endmodule

// File: rtl/ifetch_irq.sv
module ifetch_irq #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] cir_o,
  output logic [XLEN-1:0] pir_o
);

  logic [XLEN-1:0] cir_q, pir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cir_q <= '0;
      pir_q <= '0;
    end else if (step_i) begin
      cir_q <= rdata_i;
      pir_q <= cir_q;
    end
  end

  assign cir_o = cir_q;
  assign pir_o = pir_q;

endmodule

// File: rtl/ifetch_stage.sv
module ifetch_stage
  import ifetch_pkg::*;
#(
  parameter int unsigned     XLEN     = 32,
  parameter int unsigned     OP_W     = 8,
  parameter int unsigned     PC_STEP  = 4,
  parameter logic [OP_W-1:0] JMP_OP   = 8'h0B,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jmp_taken_i,
  input  logic [XLEN-1:0] jmp_target_i,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] imem_addr_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] cur_instr_o,
  output logic [XLEN-1:0] prev_instr_o,
  output logic            step_o
);

  // Opcode occupies the top OP_W bits of the word
  localparam int unsigned OP_LSB = XLEN - OP_W;

  fstate_e         state;
  logic            is_jmp;
  logic            take_jmp;
  logic            in_fill;
  logic [XLEN-1:0] next_pc;
  logic [XLEN-1:0] pc_q;

  ifetch_jdec #(
    .OP_W   (OP_W),
    .JMP_OP (JMP_OP)
  ) u_jdec (
    .opcode_i (cur_instr_o[XLEN-1:OP_LSB]),
    .is_jmp_o (is_jmp)
  );

  ifetch_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_jmp_i (is_jmp),
    .taken_i  (jmp_taken_i),
    .state_o  (state),
    .take_o   (take_jmp),
    .step_o   (step_o)
  );

  ifetch_addr #(
    .XLEN    (XLEN),
    .PC_STEP (PC_STEP)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (state),
    .take_i    (take_jmp),
    .pc_i      (pc_q),
    .target_i  (jmp_target_i),
    .addr_o    (imem_addr_o),
    .next_pc_o (next_pc)
  );

  ifetch_irq #(
    .XLEN (XLEN)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_o),
    .rdata_i (imem_rdata_i),
    .cir_o   (cur_instr_o),
    .pir_o   (prev_instr_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else begin
      pc_q <= next_pc;
    end
  end

  assign pc_o    = pc_q;
  assign in_fill = (state == FS_FILL);

endmodule

// File: rtl/ifetch_stage_chk.sv
module ifetch_stage_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fill,
  input logic            take,
  input logic            step,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] cir,
  input logic [XLEN-1:0] pir,
  input logic [XLEN-1:0] addr
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(PC_STEP);

  // R2
  seq_pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fill) |=> pc == $past(pc) + STEP_V);

  // R3
  prev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pir == $past(cir));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(pc) && $stable(cir) && $stable(pir)));

  // R5
  take_enters_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> fill);

  // R5
  fill_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> !fill);

  // R5
  fill_loads_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> pc == $past(addr));

  // R6
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fill) |-> addr == pc + STEP_V);

  // R7
  fill_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> step);

  // R7
  take_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !step);

endmodule

bind ifetch_stage ifetch_stage_chk #(
  .XLEN    (XLEN),
  .PC_STEP (PC_STEP)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .fill  (in_fill),
  .take  (take_jmp),
  .step  (step_o),
  .pc    (pc_o),
  .cir   (cur_instr_o),
  .pir   (prev_instr_o),
  .addr  (imem_addr_o)
);

// File: tb/sim_ifetch_stage.sv
`timescale 1ns/1ps
module sim_ifetch_stage;

  localparam int unsigned XLEN = 32;
  localparam logic [31:0] NOPA = 32'hFFFF_FFFF;  // stands for the all-zero word
  localparam int NV = 22;

  typedef struct packed {
    logic        tk;
    logic [31:0] tgt;
    logic        st;
    logic [31:0] ad;
    logic [31:0] pc;
    logic [31:0] ci;  // address of expected current word
    logic [31:0] pi;  // address of expected previous word
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h000, 1'b0, 32'h000, 32'h000, NOPA,     NOPA},
    '{1'b0, 32'h000, 1'b1, 32'h004, 32'h004, 32'h000,  NOPA},
    '{1'b0, 32'h000, 1'b1, 32'h008, 32'h008, 32'h004,  32'h000},
    '{1'b0, 32'h000, 1'b1, 32'h00C, 32'h00C, 32'h008,  32'h004},
    '{1'b0, 32'h000, 1'b1, 32'h010, 32'h010, 32'h00C,  32'h008},
    '{1'b1, 32'h080, 1'b0, 32'h080, 32'h010, 32'h00C,  32'h008},
    '{1'b1, 32'h044, 1'b1, 32'h080, 32'h080, 32'h080,  32'h00C},
    '{1'b1, 32'h0C0, 1'b1, 32'h084, 32'h084, 32'h080,  32'h080},
    '{1'b0, 32'h000, 1'b1, 32'h088, 32'h088, 32'h084,  32'h080},
    '{1'b0, 32'h000, 1'b1, 32'h08C, 32'h08C, 32'h088,  32'h084},
    '{1'b0, 32'h040, 1'b1, 32'h090, 32'h090, 32'h08C,  32'h088},
    '{1'b0, 32'h000, 1'b1, 32'h094, 32'h094, 32'h090,  32'h08C},
    '{1'b1, 32'h0FC, 1'b0, 32'h0FC, 32'h094, 32'h090,  32'h08C},
    '{1'b0, 32'h000, 1'b1, 32'h0FC, 32'h0FC, 32'h0FC,  32'h090},
    '{1'b0, 32'h000, 1'b1, 32'h100, 32'h100, 32'h0FC,  32'h0FC},
    '{1'b0, 32'h000, 1'b1, 32'h104, 32'h104, 32'h100,  32'h0FC},
    '{1'b0, 32'h000, 1'b1, 32'h108, 32'h108, 32'h104,  32'h100},
    '{1'b1, 32'h00C, 1'b0, 32'h00C, 32'h108, 32'h104,  32'h100},
    '{1'b0, 32'h000, 1'b1, 32'h00C, 32'h00C, 32'h00C,  32'h104},
    '{1'b1, 32'h200, 1'b0, 32'h200, 32'h00C, 32'h00C,  32'h104},
    '{1'b1, 32'h300, 1'b1, 32'h200, 32'h200, 32'h200,  32'h00C},
    '{1'b0, 32'h000, 1'b1, 32'h204, 32'h204, 32'h200,  32'h200}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            taken = 1'b0;
  logic [XLEN-1:0] target = '0;
  logic [XLEN-1:0] rdata = '0;
  logic [XLEN-1:0] addr, pc, cir, pir;
  logic            step;
  int              checks = 0;
  int              errors = 0;

  always #10 clk = ~clk;

  ifetch_stage u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .jmp_taken_i  (taken),
    .jmp_target_i (target),
    .imem_rdata_i (rdata),
    .imem_addr_o  (addr),
    .pc_o         (pc),
    .cur_instr_o  (cir),
    .prev_instr_o (pir),
    .step_o       (step)
  );

  // Program image: jumps (opcode 0x0B) at word indexes 3, 34, 36, 65
  function automatic logic [31:0] pm(input logic [31:0] a);
    logic [29:0] i;
    i = a[31:2];
    case (i)
      30'd3:   return {8'h0B, 8'h01, 8'h02, 8'h03};
      30'd34:  return {8'h0B, 8'h05, 8'h06, 8'h07};
      30'd36:  return {8'h0B, 8'h09, 8'h0A, 8'h0B};
      30'd65:  return {8'h0B, 8'h0C, 8'h0D, 8'h0E};
      default: return {8'h01, i[7:0], 8'h3C, i[15:8] ^ 8'h5A};
    endcase
  endfunction

  function automatic logic [31:0] ew(input logic [31:0] a);
    return (a == NOPA) ? 32'h0 : pm(a);
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0:              return "R1";
      5, 12, 13:      return "R5";
      6, 20:          return "R5";
      7:              return "R4";
      10:             return "R4";
      17, 18, 19:     return "R8";
      14, 15, 21:     return "R9";
      default:        return "R2";
    endcase
  endfunction

  // Synchronous-read program memory, one clock latency
  always @(posedge clk) rdata <= pm(addr);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual %0d expected %0d", 5000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, 32'h0);
    chk("R1", "cir", cir, 32'h0);
    chk("R1", "pir", pir, 32'h0);
    chk("R1", "step", {31'b0, step}, 32'h0);
    rst_n = 1'b1;

    // Vector walk; R3 and R6 and R7 are checked on every entry
    for (int k = 0; k < NV; k++) begin
      taken  = VEC[k].tk;
      target = VEC[k].tgt;
      #1;
      chk({tag_of(k), "/R7"}, "step", {31'b0, step}, {31'b0, VEC[k].st});
      chk({tag_of(k), "/R6"}, "addr", addr, VEC[k].ad);
      @(posedge clk);
      @(negedge clk);
      chk(tag_of(k), "pc", pc, VEC[k].pc);
      chk(tag_of(k), "cir", cir, ew(VEC[k].ci));
      chk({tag_of(k), "/R3"}, "pir", pir, ew(VEC[k].pi));
    end

    // Directed: reset in mid-run returns to the reset state (R1)
    taken  = 1'b0;
    target = '0;
    rst_n  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc after reset", pc, 32'h0);
    chk("R1", "cir after reset", cir, 32'h0);
    chk("R1", "pir after reset", pir, 32'h0);
    rst_n = 1'b1;
    #1;
    chk("R1", "prime step", {31'b0, step}, 32'h0);
    chk("R1", "prime addr", addr, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "prime hold pc", pc, 32'h0);
    chk("R1", "prime hold cir", cir, 32'h0);
    #1;
    chk("R2", "first step", {31'b0, step}, 32'h1);
    chk("R6", "first addr", addr, 32'h4);
    @(posedge clk);
    @(negedge clk);
    chk("R2", "first pc", pc, 32'h4);
    chk("R2", "first cir", cir, pm(32'h0));
    chk("R3", "first pir", pir, 32'h0);

    finish_run();
  end

endmodule